// File: doc/BRIEF.md
# Dual-Write-Port Memory with Last-Writer Select

This block is a memory that accepts two independent writes every clock cycle and serves several read ports at once, though each storage array inside it takes only one write per cycle. Every write port owns a full copy of the data. Port A stores only into its own copy, and port B stores only into its own copy. Each read port therefore has a copy-A replica and a copy-B replica, and each replica is reached by that port's own address.

A table with one bit per address records which port wrote that address last. The table must take two updates and answer every read port in the same cycle, so it is built from flip-flops rather than array storage. A read registers both replicas and the table bit on the same edge. A 2-to-1 multiplexer then picks the value from the last writer. There is no state machine: the control is the per-address source flag, written as an enumerated type with the values `SRC_PORT_A` and `SRC_PORT_B`.

Top module: `dual_write_mem`

## Requirements
- R1: A write on port A (`wa_en`=1) is returned by any read port that presents the same address in the next cycle, one cycle after that read address.
- R2: A write on port B (`wb_en`=1) is returned by any read port that presents the same address in the next cycle, one cycle after that read address.
- R3: When both ports write one address in different cycles, reads return the data of the later write.
- R4: When both ports write the same address in the same cycle, port A's data is what reads return afterwards.
- R5: When both ports write different addresses in the same cycle, both writes take effect.
- R6: `rd_data[p]` shows the contents at the address that `rd_addr[p]` held in the previous cycle. A write in that same cycle to that address is not yet visible.
- R7: Each read port works independently, with its own address, in every cycle.
- R8: Reset (`rst_n`=0, synchronous) clears every read output to 0 and sets every source flag to port A. Data contents are kept, so after reset each address returns what port A last stored there.
- R9: A port whose enable is 0 changes no contents, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wa_en | input | 1 | Port A write enable |
| wa_addr | input | AW | Port A write address |
| wa_data | input | WIDTH | Port A write data |
| wb_en | input | 1 | Port B write enable |
| wb_addr | input | AW | Port B write address |
| wb_data | input | WIDTH | Port B write data |
| rd_addr | input | NRD x AW | Read address per read port |
| rd_data | output | NRD x WIDTH | Registered read data per read port |

## Verification
Read data is due one edge after its address is presented. A write committed at one edge therefore reaches `rd_data` two edges after it was presented, provided that a read addresses it in the following cycle. The bench drives every input at the falling edge and takes the expected value from its model before applying that cycle's writes. It then crosses exactly one rising edge and compares at the next falling edge, so a same-cycle write shows up only in the following comparison. The checker's properties use the same two-cycle window: a `$past` of depth 2 on the write data, checked against the output one cycle after the read address.

// File: rtl/dwm_pkg.sv
package dwm_pkg;
    // which write port produced the current contents of a location
    typedef enum logic {
        SRC_PORT_A = 1'b0,
        SRC_PORT_B = 1'b1
    } src_e;
endpackage

// File: rtl/dwm_bank.sv
// One data replica: single write port, single synchronous read port.
module dwm_bank #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    // contents are deliberately not reset
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // read-before-write: same-edge write is not seen
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/dwm_flag_table.sv
// Last-writer table: two write ports, NRD read ports, flip-flops only.
module dwm_flag_table
    import dwm_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int NRD = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wa_en,
    input  logic [AW-1:0]       wa_addr,
    input  logic                wb_en,
    input  logic [AW-1:0]       wb_addr,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output src_e                rsrc [NRD]
);
    src_e flags [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                flags[i] <= SRC_PORT_A;
            end
        end else begin
            if (wb_en) begin
                flags[wb_addr] <= SRC_PORT_B;
            end
            // port A written last so it wins a same-address collision
            if (wa_en) begin
                flags[wa_addr] <= SRC_PORT_A;
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rsrc[p] <= SRC_PORT_A;
            end else begin
                rsrc[p] <= flags[raddr[p]];
            end
        end
    end
endmodule

// File: rtl/dual_write_mem.sv
module dual_write_mem
    import dwm_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    parameter int NRD = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wa_en,
    input  logic [AW-1:0]             wa_addr,
    input  logic [WIDTH-1:0]          wa_data,
    input  logic                      wb_en,
    input  logic [AW-1:0]             wb_addr,
    input  logic [WIDTH-1:0]          wb_data,
    input  logic [NRD-1:0][AW-1:0]    rd_addr,
    output logic [NRD-1:0][WIDTH-1:0] rd_data
);
    src_e             sel_q [NRD];
    logic [WIDTH-1:0] a_q   [NRD];
    logic [WIDTH-1:0] b_q   [NRD];

    dwm_flag_table #(.DEPTH(DEPTH), .NRD(NRD)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (wa_en),
        .wa_addr (wa_addr),
        .wb_en   (wb_en),
        .wb_addr (wb_addr),
        .raddr   (rd_addr),
        .rsrc    (sel_q)
    );

    // one A replica and one B replica per read port
    for (genvar p = 0; p < NRD; p++) begin : g_port
        dwm_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank_a (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wa_en),
            .waddr (wa_addr),
            .wdata (wa_data),
            .raddr (rd_addr[p]),
            .rdata (a_q[p])
        );

        dwm_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank_b (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wb_en),
            .waddr (wb_addr),
            .wdata (wb_data),
            .raddr (rd_addr[p]),
            .rdata (b_q[p])
        );

        always_comb begin
            unique case (sel_q[p])
                SRC_PORT_B: rd_data[p] = b_q[p];
                default:    rd_data[p] = a_q[p];
            endcase
        end
    end
endmodule

// File: rtl/dwm_checker.sv
module dwm_checker #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 32,
    parameter int NRD = 2,
    localparam int AW = $clog2(DEPTH)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wa_en,
    input logic [AW-1:0]             wa_addr,
    input logic [WIDTH-1:0]          wa_data,
    input logic                      wb_en,
    input logic [AW-1:0]             wb_addr,
    input logic [WIDTH-1:0]          wb_data,
    input logic [NRD-1:0][AW-1:0]    rd_addr,
    input logic [NRD-1:0][WIDTH-1:0] rd_data
);
    logic rst_edge_seen;

    always_ff @(posedge clk) begin
        rst_edge_seen <= !rst_n;
    end

    // R8
    always @(negedge clk) begin
        if (!rst_n && rst_edge_seen) begin
            rd_zero_in_reset_chk: assert (rd_data == '0);
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_chk
        // R1
        a_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wa_en) && rd_addr[p] == $past(wa_addr))
            |=> rd_data[p] == $past(wa_data, 2));

        // R2
        b_write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wb_en) && !($past(wa_en) && $past(wa_addr) == $past(wb_addr))
             && rd_addr[p] == $past(wb_addr))
            |=> rd_data[p] == $past(wb_data, 2));

        // R4
        collision_a_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wa_en && wb_en && wa_addr == wb_addr) && rd_addr[p] == $past(wb_addr))
            |=> rd_data[p] == $past(wa_data, 2));
    end

    if (NRD > 1) begin : g_pair
        // R7
        ports_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr[0] == rd_addr[1]) |=> rd_data[0] == rd_data[1]);
    end
endmodule

bind dual_write_mem dwm_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wa_en   (wa_en),
    .wa_addr (wa_addr),
    .wa_data (wa_data),
    .wb_en   (wb_en),
    .wb_addr (wb_addr),
    .wb_data (wb_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/tb_dual_write_mem.sv
`timescale 1ns/1ps
module tb_dual_write_mem;
    localparam int DEPTH = 32;
    localparam int WIDTH = 32;
    localparam int NRD = 2;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wa_en = 1'b0, wb_en = 1'b0;
    logic [AW-1:0] wa_addr = '0, wb_addr = '0;
    logic [WIDTH-1:0] wa_data = '0, wb_data = '0;
    logic [NRD-1:0][AW-1:0] rd_addr = '0;
    logic [NRD-1:0][WIDTH-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference: two copies plus last writer per address
    logic [WIDTH-1:0] ref_a [DEPTH];
    logic [WIDTH-1:0] ref_b [DEPTH];
    bit               ref_from_b [DEPTH];

    always #5 clk = ~clk;

    dual_write_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) dut (
        .clk(clk), .rst_n(rst_n),
        .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [WIDTH-1:0] ref_read(input int a);
        return ref_from_b[a] ? ref_b[a] : ref_a[a];
    endfunction

    task automatic check(input string req, input int port,
                         input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s port%0d actual=%h expected=%h", req, port, act, exp);
        end
    endtask

    // called at a falling edge; one cycle of stimulus, compare after the next rising edge
    task automatic step(input string req, input bit chk,
                        input bit ae, input int aa, input logic [WIDTH-1:0] ad,
                        input bit be, input int ba, input logic [WIDTH-1:0] bd,
                        input int r0, input int r1);
        logic [WIDTH-1:0] exp0, exp1;
        wa_en = ae; wa_addr = AW'(aa); wa_data = ad;
        wb_en = be; wb_addr = AW'(ba); wb_data = bd;
        rd_addr[0] = AW'(r0); rd_addr[1] = AW'(r1);
        exp0 = ref_read(r0);
        exp1 = ref_read(r1);
        if (be) begin ref_b[ba] = bd; ref_from_b[ba] = 1'b1; end
        if (ae) begin ref_a[aa] = ad; ref_from_b[aa] = 1'b0; end
        @(posedge clk);
        @(negedge clk);
        if (chk) begin
            check(req, 0, rd_data[0], exp0);
            check(req, 1, rd_data[1], exp1);
        end
    endtask

    task automatic idle_read(input string req, input int r0, input int r1);
        step(req, 1'b1, 1'b0, 0, '0, 1'b0, 0, '0, r0, r1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            ref_a[i] = '0; ref_b[i] = '0; ref_from_b[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: outputs held at zero in reset
        check("R8", 0, rd_data[0], '0);
        check("R8", 1, rd_data[1], '0);
        rst_n = 1'b1;

        // fill copy A so every location holds a known value
        for (int i = 0; i < DEPTH; i++) begin
            step("fill", 1'b0, 1'b1, i, 32'hA000_0000 + i, 1'b0, 0, '0, 0, 0);
        end
        idle_read("R7", 4, 17);

        // R1 then R2 then R3 on one address
        step("R1", 1'b1, 1'b1, 3, 32'h1111_0003, 1'b0, 0, '0, 3, 3);
        idle_read("R1", 3, 5);
        step("R2", 1'b1, 1'b0, 0, '0, 1'b1, 3, 32'h2222_0003, 5, 3);
        idle_read("R2", 3, 3);
        step("R3", 1'b1, 1'b1, 3, 32'h3333_0003, 1'b0, 0, '0, 3, 6);
        idle_read("R3", 6, 3);

        // R4: same address, same cycle
        step("R4", 1'b1, 1'b1, 7, 32'h4444_AAAA, 1'b1, 7, 32'h4444_BBBB, 7, 1);
        idle_read("R4", 7, 7);

        // R5: different addresses, same cycle
        step("R5", 1'b1, 1'b1, 9, 32'h5555_0009, 1'b1, 10, 32'h5555_000A, 9, 10);
        idle_read("R5", 9, 10);
        idle_read("R7", 10, 9);

        // R6: read in the write cycle returns old data
        step("R6", 1'b1, 1'b0, 0, '0, 1'b1, 12, 32'h6666_000C, 12, 12);
        idle_read("R6", 12, 11);

        // R9: disabled ports with live address and data
        step("R9", 1'b1, 1'b0, 9, 32'hDEAD_BEEF, 1'b0, 10, 32'hFEED_FACE, 9, 10);
        idle_read("R9", 9, 10);

        // R8: flags return to port A, data retained
        step("R8", 1'b1, 1'b0, 0, '0, 1'b1, 20, 32'h8888_0014, 20, 20);
        idle_read("R8", 20, 21);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R8", 0, rd_data[0], '0);
        check("R8", 1, rd_data[1], '0);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) ref_from_b[i] = 1'b0;
        idle_read("R8", 20, 12);
        idle_read("R8", 3, 7);

        // mixed traffic over a narrow address range for frequent collisions
        for (int n = 0; n < 400; n++) begin
            step("R3", 1'b1,
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), WIDTH'($urandom),
                 1'($urandom_range(0, 1)), int'($urandom_range(0, 7)), WIDTH'($urandom),
                 int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule